// File: doc/BRIEF.md
# Stereo DAC Channel Router with Zero-Run Mute

This block sits between a serial audio receiver and the DAC interpolation filters. On each sample strobe it takes one signed left/right input pair and produces one registered left/right output pair. Each output picks, on its own, silence, the left input, the right input or the mean of the two.

A 9-bit control word arrives on a small register port. It holds a 4-bit routing field, an enable for zero-run muting and a flag that tells a downstream attenuator to apply the left channel's setting to the right channel. The block keeps a written word in a pending copy and puts it in force only at a sample strobe, so every output pair is built from one consistent control word.

When zero-run muting is enabled, a long run of all-zero input pairs forces both outputs to the mid-level code, which is signed zero. The first pair that is not zero lifts the mute at once.

Top module: `stereo_router`

## Requirements
- R1: For each cycle with `smp_valid_i` high, `out_valid_o` is high in the next cycle and `out_left_o`/`out_right_o` carry that pair's result. In every other cycle `out_valid_o` is low and both outputs hold their previous values.
- R2: A write with `reg_we_i` high and `reg_addr_i` equal to 2 stores `reg_wdata_i`. Bit 3 is the attenuation-share flag, bit 4 is the zero-run enable and bits 8:5 are the routing field. Writes to any other address have no effect.
- R3: After reset the routing field is 4'b1001, so left goes to left and right goes to right. The share flag and the zero-run enable are 0, and all outputs are 0.
- R4: Routing bits 6:5 of the word select the left output and bits 8:7 select the right output. Code 00 is mute (output 0), 01 is the left input, 10 is the right input and 11 is the average.
- R5: The average is the sum of the two inputs, widened by one sign bit and shifted right arithmetically by one. It never overflows and rounds toward minus infinity.
- R6: A written word takes effect at the first sample strobe in a later cycle. `att_share_o` changes only in the cycle after a strobe, and then shows bit 3 of the word in force.
- R7: With the zero-run enable set, the 1024th consecutive input pair in which both words are zero, and every further zero pair, gives `zero_mute_o` = 1 and both outputs 0. Fewer zero pairs give no mute.
- R8: The first pair with either word non-zero clears `zero_mute_o` for that same output sample, and its routed result is output unchanged.
- R9: A pair counts as zero only when both words are zero. Any non-zero pair restarts the run count from zero.
- R10: With the zero-run enable clear, no mute occurs and the run count is held at zero. Clearing the enable lifts an active mute at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 7 | Register address |
| reg_wdata_i | input | 9 | Register write data |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_left_i | input | 24 | Signed left input sample |
| smp_right_i | input | 24 | Signed right input sample |
| out_valid_o | output | 1 | Output sample strobe |
| out_left_o | output | 24 | Signed left DAC sample |
| out_right_o | output | 24 | Signed right DAC sample |
| att_share_o | output | 1 | Right channel uses the left attenuation setting |
| zero_mute_o | output | 1 | Zero-run mute active for this output sample |

## Verification
All sixteen routing codes are driven with full-scale positive inputs and with a -1/0 pair. The first pattern shows whether the average overflows. The second shows whether it rounds toward minus infinity or toward zero. Runs of 1023 and 1024 zero pairs locate the exact mute threshold. A pair with only one word non-zero, placed inside a run, shows whether the run restarts. Random pairs with sparse zeros, under changing control words, check that each output uses the control word pending at its own strobe.

// File: rtl/stereo_router_pkg.sv
`timescale 1ns/1ps
package stereo_router_pkg;
  typedef enum logic [1:0] {
    SEL_MUTE  = 2'b00,
    SEL_LEFT  = 2'b01,
    SEL_RIGHT = 2'b10,
    SEL_AVG   = 2'b11
  } sel_e;

  // packed MSB first: matches word bits [8:3]
  typedef struct packed {
    sel_e right_sel;
    sel_e left_sel;
    logic zero_en;
    logic att_share;
  } ctrl_t;

  localparam int CTRL_LSB = 3;
  localparam int CTRL_MSB = 8;
  localparam ctrl_t CTRL_RESET = '{right_sel: SEL_RIGHT, left_sel: SEL_LEFT,
                                   zero_en: 1'b0, att_share: 1'b0};
endpackage

// File: rtl/router_ctrl_reg.sv
`timescale 1ns/1ps
module router_ctrl_reg
  import stereo_router_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int WORD_W    = 9,
  parameter int CTRL_ADDR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              strobe_i,
  output ctrl_t             pending_o,
  output ctrl_t             active_o
);
  logic unused_low;
  assign unused_low = ^wdata_i[CTRL_LSB-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= CTRL_RESET;
      active_o  <= CTRL_RESET;
    end else begin
      if (we_i && addr_i == ADDR_W'(CTRL_ADDR))
        pending_o <= ctrl_t'(wdata_i[CTRL_MSB:CTRL_LSB]);
      if (strobe_i)
        active_o <= pending_o;
    end
  end
endmodule

// File: rtl/router_zero_run.sv
`timescale 1ns/1ps
module router_zero_run #(
  parameter int RUN_LEN = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic en_i,
  input  logic is_zero_i,
  output logic mute_now_o
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] run_q;

  // mute decided for the sample on the strobe itself
  assign mute_now_o = en_i && is_zero_i && (run_q >= CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (strobe_i) begin
      if (!en_i || !is_zero_i) run_q <= '0;
      else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/router_chan_sel.sv
`timescale 1ns/1ps
module router_chan_sel
  import stereo_router_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  sel_e              sel_i,
  input  logic              mute_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic [DATA_W-1:0] data_o
);
  logic signed [DATA_W:0] sum;
  logic        [DATA_W-1:0] avg;

  assign sum = $signed({left_i[DATA_W-1], left_i}) + $signed({right_i[DATA_W-1], right_i});
  assign avg = sum[DATA_W:1];

  always_comb begin
    if (mute_i) data_o = '0;
    else begin
      unique case (sel_i)
        SEL_MUTE:  data_o = '0;
        SEL_LEFT:  data_o = left_i;
        SEL_RIGHT: data_o = right_i;
        SEL_AVG:   data_o = avg;
        default:   data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/stereo_router.sv
`timescale 1ns/1ps
module stereo_router
  import stereo_router_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int ADDR_W    = 7,
  parameter int WORD_W    = 9,
  parameter int CTRL_ADDR = 2,
  parameter int RUN_LEN   = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_left_i,
  input  logic [DATA_W-1:0] smp_right_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_left_o,
  output logic [DATA_W-1:0] out_right_o,
  output logic              att_share_o,
  output logic              zero_mute_o
);
  localparam int N_CH = 2;

  ctrl_t pending, active;
  logic  is_zero, mute_now;
  sel_e  ch_sel [N_CH];
  logic [DATA_W-1:0] ch_data [N_CH];

  router_ctrl_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CTRL_ADDR(CTRL_ADDR)) i_ctrl (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .strobe_i(smp_valid_i), .pending_o(pending), .active_o(active)
  );

  assign is_zero = (smp_left_i == '0) && (smp_right_i == '0);

  router_zero_run #(.RUN_LEN(RUN_LEN)) i_zrun (
    .clk_i, .rst_ni, .strobe_i(smp_valid_i), .en_i(pending.zero_en),
    .is_zero_i(is_zero), .mute_now_o(mute_now)
  );

  assign ch_sel[0] = pending.left_sel;
  assign ch_sel[1] = pending.right_sel;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    router_chan_sel #(.DATA_W(DATA_W)) i_sel (
      .sel_i(ch_sel[c]), .mute_i(mute_now), .left_i(smp_left_i),
      .right_i(smp_right_i), .data_o(ch_data[c])
    );
  end

  assign att_share_o = active.att_share;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_left_o  <= '0;
      out_right_o <= '0;
      zero_mute_o <= 1'b0;
    end else begin
      out_valid_o <= smp_valid_i;
      if (smp_valid_i) begin
        out_left_o  <= ch_data[0];
        out_right_o <= ch_data[1];
        zero_mute_o <= mute_now;
      end
    end
  end
endmodule

// File: rtl/stereo_router_chk.sv
`timescale 1ns/1ps
module stereo_router_chk #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 7,
  parameter int WORD_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [WORD_W-1:0] reg_wdata_i,
  input logic              smp_valid_i,
  input logic [DATA_W-1:0] smp_left_i,
  input logic [DATA_W-1:0] smp_right_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_left_o,
  input logic [DATA_W-1:0] out_right_o,
  input logic              att_share_o,
  input logic              zero_mute_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> out_valid_o); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> (!out_valid_o && $stable(out_left_o) && $stable(out_right_o))); // R1
  AST_SHARE_AT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(att_share_o)); // R6
  AST_MUTE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_mute_o |-> (out_left_o == '0 && out_right_o == '0)); // R7
  AST_MUTE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && (smp_left_i != '0 || smp_right_i != '0)) |=> !zero_mute_o); // R8
endmodule

bind stereo_router stereo_router_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_stereo_router.sv
`timescale 1ns/1ps
module test_stereo_router;
  localparam int DW = 24;
  localparam int RUN = 1024;

  logic clk = 0, rst_n = 0;
  logic we = 0;
  logic [6:0] addr = '0;
  logic [8:0] wdata = '0;
  logic sv = 0;
  logic [DW-1:0] sl = '0, sr = '0;
  logic ov, zm, att;
  logic [DW-1:0] ol, orr;

  int n_chk = 0, n_bad = 0;
  logic [8:0] m_word = 9'b1001_0_0_000;
  logic m_att = 0;
  int m_run = 0;

  always #5 clk = ~clk;

  stereo_router i_stereo_router (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .smp_valid_i(sv), .smp_left_i(sl), .smp_right_i(sr), .out_valid_o(ov),
    .out_left_o(ol), .out_right_o(orr), .att_share_o(att), .zero_mute_o(zm)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] route(logic [1:0] c, logic [DW-1:0] l, logic [DW-1:0] r);
    logic signed [DW:0] s;
    s = $signed({l[DW-1], l}) + $signed({r[DW-1], r});
    case (c)
      2'b00: return '0;
      2'b01: return l;
      2'b10: return r;
      default: return DW'(s >>> 1);
    endcase
  endfunction

  task automatic reg_write(logic [6:0] a, logic [8:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
    if (a == 7'd2) m_word = d;
  endtask

  task automatic send(logic [DW-1:0] l, logic [DW-1:0] r, string req);
    logic mute;
    logic [DW-1:0] el, er;
    logic z;
    z = (l == '0) && (r == '0);
    if (!m_word[4]) begin mute = 0; m_run = 0; end
    else if (z) begin mute = (m_run >= RUN - 1); if (m_run < RUN) m_run++; end
    else begin mute = 0; m_run = 0; end
    el = mute ? '0 : route(m_word[6:5], l, r);
    er = mute ? '0 : route(m_word[8:7], l, r);
    m_att = m_word[3];
    @(negedge clk);
    sv = 1; sl = l; sr = r;
    @(negedge clk);
    sv = 0;
    chk({req, " R1 valid"}, 64'(ov), 64'(1));
    chk({req, " left"}, 64'(ol), 64'(el));
    chk({req, " right"}, 64'(orr), 64'(er));
    chk({req, " R7 mute"}, 64'(zm), 64'(mute));
    chk({req, " R6 share"}, 64'(att), 64'(m_att));
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    chk("R3 out_valid", 64'(ov), 0);
    chk("R3 left", 64'(ol), 0);
    chk("R3 right", 64'(orr), 0);
    chk("R3 share", 64'(att), 0);
    chk("R3 mute", 64'(zm), 0);
    send(24'd100, -24'sd200, "R3 default route");

    // R2 other address ignored
    reg_write(7'd5, 9'b0000_1_1_000);
    send(24'd7, 24'd9, "R2 ignored addr");

    // R1 hold while idle
    @(negedge clk);
    chk("R1 idle valid", 64'(ov), 0);
    chk("R1 hold left", 64'(ol), 64'(24'd7));

    // R4 R5 all codes, overflow and rounding
    for (int code = 0; code < 16; code++) begin
      reg_write(7'd2, {4'(code), 5'b0});
      send(24'h7FFFFF, 24'h7FFFFF, "R4 R5 fullscale");
      send(-24'sd1, 24'd0, "R4 R5 floor");
      send(24'h123456, -24'sd77, "R4 mix");
    end

    // R6 share flag takes effect at strobe, not at write
    reg_write(7'd2, 9'b1001_0_1_000);
    chk("R6 before strobe", 64'(att), 0);
    send(24'd1, 24'd2, "R6 apply");
    reg_write(7'd2, 9'b1001_0_0_000);
    chk("R6 hold after write", 64'(att), 1);
    send(24'd1, 24'd2, "R6 clear");

    // R7 threshold, R8 release
    reg_write(7'd2, 9'b1111_1_0_000);
    for (int i = 0; i < RUN - 1; i++) send('0, '0, "R7 below");
    send('0, '0, "R7 at threshold");
    chk("R7 flag", 64'(zm), 1);
    send('0, '0, "R7 sustained");
    send(24'd5, 24'd3, "R8 release");
    chk("R8 flag", 64'(zm), 0);

    // R9 one word non-zero restarts the run
    for (int i = 0; i < RUN - 1; i++) send('0, '0, "R9 run");
    send('0, 24'd5, "R9 half zero");
    for (int i = 0; i < RUN - 1; i++) send('0, '0, "R9 restart");
    send('0, '0, "R9 full run");
    chk("R9 flag", 64'(zm), 1);

    // R10 disable lifts mute and holds count
    reg_write(7'd2, 9'b1111_0_0_000);
    send('0, '0, "R10 disabled");
    chk("R10 flag", 64'(zm), 0);
    for (int i = 0; i < RUN + 20; i++) send('0, '0, "R10 no mute");
    reg_write(7'd2, 9'b1111_1_0_000);
    send('0, '0, "R10 count restarted");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [DW-1:0] l, r;
      if ($urandom_range(0, 9) == 0) reg_write(7'($urandom_range(0, 3)), 9'($urandom));
      l = ($urandom_range(0, 3) == 0) ? '0 : DW'($urandom);
      r = ($urandom_range(0, 3) == 0) ? '0 : DW'($urandom);
      send(l, r, "R4 R9 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule